// File: doc/BRIEF.md
# Segmented Block Copy Engine

This block moves a run of elements, bytes or 16-bit words, from one memory region to another. Each region is named by a 16-bit segment and a 16-bit offset. The engine turns every pair into a 20-bit physical address by shifting the segment left four places and adding the offset. A single-cycle start pulse loads the whole setup: source and destination segment and offset, an element count, a width select and a direction select.

For every element the engine issues one read and then one write on a simple synchronous memory port. A ready input stalls either access for as long as it stays low. After each write is accepted, both offsets step and the count drops by one. The copy ends when the count reaches zero.

An interrupt request makes the engine finish the element it is working on and then park. While it is parked, the live count and both offsets can be seen on the outputs. A resume pulse restarts the copy from exactly those values.

Top module: `seg_copy_engine`

## Requirements
- R1: Every memory address equals (segment × 16 + offset) mod 2^20. The source side uses the source segment and offset, and the destination side uses the destination segment and offset.
- R2: Each element is one read (mem_we_o=0) followed by one write (mem_we_o=1). The written data equals the data read: all 16 bits in word mode, or bits 7:0 in byte mode.
- R3: The count drops by one per accepted write. When it reaches zero, no further access is made and done_o is high for exactly one cycle, the cycle after the last write is accepted.
- R4: With dir_dec_i=0 both offsets increase after each element, by 1 in byte mode (word_i=0) and by 2 in word mode (word_i=1). mem_word_o shows the width.
- R5: With dir_dec_i=1 both offsets decrease by the same step.
- R6: Offsets wrap modulo 65536 inside their segment, and the physical address wraps modulo 2^20.
- R7: A start with count 0 makes no memory access and raises done_o in the cycle right after the start.
- R8: While mem_req_o is high and mem_ready_i is low, the request, the address and the write select hold steady into the next cycle.
- R9: An irq_i pulse during a copy that is not on its last element lets the current element finish. The engine then sets paused_o, makes no accesses, and shows the remaining count and the current offsets. A resume_i pulse continues from those values.
- R10: start_i has no effect while a copy is running or paused.
- R11: After reset the engine is idle: no request, done_o=0, busy_o=0, count_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Load the setup and begin a copy (honoured only when idle) |
| word_i | input | 1 | 1 = 16-bit elements, 0 = bytes |
| dir_dec_i | input | 1 | 1 = offsets decrease, 0 = offsets increase |
| src_seg_i | input | 16 | Source segment |
| src_off_i | input | 16 | Source offset |
| dst_seg_i | input | 16 | Destination segment |
| dst_off_i | input | 16 | Destination offset |
| count_i | input | 16 | Number of elements |
| irq_i | input | 1 | Pause request |
| resume_i | input | 1 | Continue a paused copy |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_word_o | output | 1 | Access width, 1 = word |
| mem_addr_o | output | 20 | Physical address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, taken when the read is accepted |
| mem_ready_i | input | 1 | Access accepted at this clock edge |
| busy_o | output | 1 | Copy running or paused |
| paused_o | output | 1 | Parked after an interrupt request |
| done_o | output | 1 | One-cycle completion pulse |
| count_o | output | 16 | Remaining element count |
| src_off_o | output | 16 | Current source offset |
| dst_off_o | output | 16 | Current destination offset |

## Verification
A wrong offset or segment register shows up as a bad address on the very next access. A step error or a missed wrap appears on the first access after the element that applied it. A lost or stale data register is caught at the write of that same element. Count errors show up as extra or missing accesses, or as a done pulse that comes in the wrong cycle. At a pause or at completion, the exposed count and offsets are compared directly with the expected values. A broken stall path shows as a changed address in the cycle after a refused request.

// File: rtl/seg_copy_pkg.sv
package seg_copy_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_PAUSE,
    ST_DONE
  } cp_state_e;
endpackage

// File: rtl/seg_phys_addr.sv
module seg_phys_addr #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int PHYS_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [PHYS_W-1:0] phys_o
);
  logic [PHYS_W-1:0] seg_base, off_ext;
  assign seg_base = {seg_i, {SHIFT{1'b0}}};
  assign off_ext  = {{(PHYS_W-OFF_W){1'b0}}, off_i};
  assign phys_o   = seg_base + off_ext;  // wraps modulo 2^PHYS_W
endmodule

// File: rtl/idx_stepper.sv
module idx_stepper #(
  parameter int OFF_W = 16
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic             word_i,
  input  logic             dec_i,
  output logic [OFF_W-1:0] off_o
);
  logic [OFF_W-1:0] step;
  assign step  = word_i ? OFF_W'(2) : OFF_W'(1);
  assign off_o = dec_i ? off_i - step : off_i + step;
endmodule

// File: rtl/cp_down_counter.sv
module cp_down_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (load_i) cnt_o <= load_val_i;
    else if (dec_i)  cnt_o <= cnt_o - 1'b1;
  end
  assign last_o = (cnt_o == CNT_W'(1));
endmodule

// File: rtl/seg_copy_engine.sv
module seg_copy_engine
  import seg_copy_pkg::*;
#(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int CNT_W  = 16,
  parameter int SHIFT  = 4,
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  localparam int PHYS_W = SEG_W + SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              word_i,
  input  logic              dir_dec_i,
  input  logic [SEG_W-1:0]  src_seg_i,
  input  logic [OFF_W-1:0]  src_off_i,
  input  logic [SEG_W-1:0]  dst_seg_i,
  input  logic [OFF_W-1:0]  dst_off_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              irq_i,
  input  logic              resume_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_word_o,
  output logic [PHYS_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i,
  output logic              busy_o,
  output logic              paused_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [OFF_W-1:0]  src_off_o,
  output logic [OFF_W-1:0]  dst_off_o
);
  cp_state_e state_q, state_d;
  logic [SEG_W-1:0]  sseg_q, dseg_q;
  logic [OFF_W-1:0]  soff_q, doff_q, soff_nxt, doff_nxt;
  logic [DATA_W-1:0] data_q;
  logic              word_q, dec_q, pend_q;
  logic [PHYS_W-1:0] src_phys, dst_phys;
  logic              launch, rd_acc, wr_acc, cnt_last, active;

  assign launch = start_i && (state_q == ST_IDLE);
  assign rd_acc = (state_q == ST_READ)  && mem_ready_i;
  assign wr_acc = (state_q == ST_WRITE) && mem_ready_i;
  assign active = (state_q == ST_READ) || (state_q == ST_WRITE);

  seg_phys_addr #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .PHYS_W(PHYS_W))
    u_src_addr (.seg_i(sseg_q), .off_i(soff_q), .phys_o(src_phys));
  seg_phys_addr #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .PHYS_W(PHYS_W))
    u_dst_addr (.seg_i(dseg_q), .off_i(doff_q), .phys_o(dst_phys));

  idx_stepper #(.OFF_W(OFF_W))
    u_src_step (.off_i(soff_q), .word_i(word_q), .dec_i(dec_q), .off_o(soff_nxt));
  idx_stepper #(.OFF_W(OFF_W))
    u_dst_step (.off_i(doff_q), .word_i(word_q), .dec_i(dec_q), .off_o(doff_nxt));

  cp_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .load_i(launch), .load_val_i(count_i), .dec_i(wr_acc),
    .cnt_o(count_o), .last_o(cnt_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = (count_i == '0) ? ST_DONE : ST_READ;
      ST_READ:  if (mem_ready_i) state_d = ST_WRITE;
      ST_WRITE: if (mem_ready_i) begin
                  if (cnt_last)               state_d = ST_DONE;
                  else if (pend_q || irq_i)   state_d = ST_PAUSE;
                  else                        state_d = ST_READ;
                end
      ST_PAUSE: if (resume_i) state_d = ST_READ;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sseg_q  <= '0;
      dseg_q  <= '0;
      soff_q  <= '0;
      doff_q  <= '0;
      word_q  <= 1'b0;
      dec_q   <= 1'b0;
      pend_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      pend_q  <= active && !wr_acc && (pend_q || irq_i);
      if (launch) begin
        sseg_q <= src_seg_i;
        dseg_q <= dst_seg_i;
        soff_q <= src_off_i;
        doff_q <= dst_off_i;
        word_q <= word_i;
        dec_q  <= dir_dec_i;
      end else if (wr_acc) begin
        soff_q <= soff_nxt;
        doff_q <= doff_nxt;
      end
      if (rd_acc)
        data_q <= word_q ? mem_rdata_i
                         : {{(DATA_W-BYTE_W){1'b0}}, mem_rdata_i[BYTE_W-1:0]};
    end
  end

  assign mem_req_o   = active;
  assign mem_we_o    = (state_q == ST_WRITE);
  assign mem_word_o  = word_q;
  assign mem_addr_o  = mem_we_o ? dst_phys : src_phys;
  assign mem_wdata_o = data_q;
  assign busy_o      = active || (state_q == ST_PAUSE);
  assign paused_o    = (state_q == ST_PAUSE);
  assign done_o      = (state_q == ST_DONE);
  assign src_off_o   = soff_q;
  assign dst_off_o   = doff_q;

  // R8
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
  // R2
  read_then_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && mem_ready_i) |=> (mem_req_o && mem_we_o));
  // R3
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_ready_i) |=> (count_o == $past(count_o) - 1'b1));
  // R3
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  zero_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !done_o && count_i == '0) |=> (done_o && !mem_req_o));
  // R9
  pause_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paused_o |-> !mem_req_o);
endmodule

// File: tb/seg_copy_engine_test.sv
module seg_copy_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 0, word_i = 0, dir_dec_i = 0, irq_i = 0, resume_i = 0;
  logic [15:0] src_seg_i = 0, src_off_i = 0, dst_seg_i = 0, dst_off_i = 0, count_i = 0;
  logic        mem_req_o, mem_we_o, mem_word_o, mem_ready_i = 0;
  logic [19:0] mem_addr_o;
  logic [15:0] mem_wdata_o, mem_rdata_i = 0;
  logic        busy_o, paused_o, done_o;
  logic [15:0] count_o, src_off_o, dst_off_o;

  always #5 clk = ~clk;

  seg_copy_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i, .word_i, .dir_dec_i,
    .src_seg_i, .src_off_i, .dst_seg_i, .dst_off_i, .count_i,
    .irq_i, .resume_i, .mem_req_o, .mem_we_o, .mem_word_o, .mem_addr_o,
    .mem_wdata_o, .mem_rdata_i, .mem_ready_i, .busy_o, .paused_o, .done_o,
    .count_o, .src_off_o, .dst_off_o
  );

  int n_chk = 0, n_err = 0;
  bit [7:0] mem [int];

  // expected engine state
  bit        active = 0, phase = 0, e_word = 0, e_dec = 0, exp_done = 0, zero_arm = 0;
  bit [15:0] e_sseg, e_dseg, e_soff, e_doff, e_cnt, exp_data;
  bit        stall_prev = 0, stall_we;
  bit [19:0] stall_addr;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit [19:0] phys(bit [15:0] seg, bit [15:0] off);
    return 20'({seg, 4'b0} + {4'b0, off});
  endfunction

  function automatic bit [7:0] rd_byte(bit [19:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h5a;
  endfunction

  function automatic bit [15:0] rd_elem(bit [19:0] a, bit w);
    return w ? {rd_byte(a + 20'd1), rd_byte(a)} : {8'h00, rd_byte(a)};
  endfunction

  function automatic bit [15:0] step_off(bit [15:0] o, bit w, bit d);
    bit [15:0] s = w ? 16'd2 : 16'd1;
    return d ? o - s : o + s;
  endfunction

  // memory model and access scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      bit [19:0] ea;
      bit        rdy;
      if (done_o || exp_done || zero_arm)
        chk(done_o == (exp_done || zero_arm), "R3", "done pulse timing", done_o, exp_done || zero_arm);
      exp_done = 0;
      zero_arm = 0;
      if (stall_prev)
        chk(mem_req_o && mem_addr_o == stall_addr && mem_we_o == stall_we,
            "R8", "stalled access not held", mem_addr_o, stall_addr);
      ea = phase ? phys(e_dseg, e_doff) : phys(e_sseg, e_soff);
      if (mem_req_o) begin
        if (!active) chk(0, "R3", "access outside a copy", mem_addr_o, 0);
        else begin
          chk(mem_addr_o == ea, "R1", "address", mem_addr_o, ea);
          chk(mem_we_o == phase, "R2", "read/write order", mem_we_o, phase);
          chk(mem_word_o == e_word, "R4", "width", mem_word_o, e_word);
        end
      end
      rdy = ($urandom_range(0, 3) != 0);
      mem_ready_i = rdy;
      stall_prev = mem_req_o && !rdy;
      stall_addr = mem_addr_o;
      stall_we   = mem_we_o;
      if (mem_req_o && rdy && active) begin
        if (!phase) begin
          exp_data    = rd_elem(ea, e_word);
          mem_rdata_i = e_word ? exp_data : {$urandom_range(0, 255) & 8'hff, exp_data[7:0]};
          phase = 1;
        end else begin
          chk((e_word ? mem_wdata_o : {8'h00, mem_wdata_o[7:0]}) == exp_data,
              "R2", "write data", mem_wdata_o, exp_data);
          mem[int'(ea)] = exp_data[7:0];
          if (e_word) mem[int'(ea + 20'd1)] = exp_data[15:8];
          e_soff = step_off(e_soff, e_word, e_dec);
          e_doff = step_off(e_doff, e_word, e_dec);
          e_cnt  = e_cnt - 16'd1;
          phase  = 0;
          if (e_cnt == 0) begin
            exp_done = 1;
            active   = 0;
          end
        end
      end
    end
  end

  task automatic run_copy(bit w, bit d, bit [15:0] ss, bit [15:0] so, bit [15:0] ds,
                          bit [15:0] dof, bit [15:0] cnt, bit do_irq, bit do_restart);
    int guard;
    bit fired = 0, restarted = 0;
    @(negedge clk); #1;
    start_i = 1; word_i = w; dir_dec_i = d;
    src_seg_i = ss; src_off_i = so; dst_seg_i = ds; dst_off_i = dof; count_i = cnt;
    e_word = w; e_dec = d; e_sseg = ss; e_soff = so; e_dseg = ds; e_doff = dof;
    e_cnt = cnt; phase = 0;
    if (cnt == 0) zero_arm = 1; else active = 1;
    @(negedge clk); #1;
    start_i = 0;
    if (cnt == 0) begin
      chk(!mem_req_o && !busy_o, "R7", "zero count started a copy", mem_req_o, 0);
      @(negedge clk); #1;
      chk(!mem_req_o && !done_o, "R7", "zero count idle after done", done_o, 0);
      return;
    end
    guard = 0;
    while (active && guard < 2000) begin
      if (do_irq && !fired && e_cnt >= 2 && e_cnt <= cnt - 1 && !phase) begin
        irq_i = 1;
        fired = 1;
        @(negedge clk); #1;
        irq_i = 0;
        for (int k = 0; k < 20 && !paused_o; k++) begin @(negedge clk); #1; end
        chk(paused_o, "R9", "no pause after irq", paused_o, 1);
        chk(count_o == e_cnt, "R9", "count at pause", count_o, e_cnt);
        chk(src_off_o == e_soff, "R9", "src offset at pause", src_off_o, e_soff);
        chk(dst_off_o == e_doff, "R9", "dst offset at pause", dst_off_o, e_doff);
        start_i = 1; src_off_i = ~so; count_i = 16'd1;  // R10: ignored while paused
        for (int k = 0; k < 4; k++) begin
          @(negedge clk); #1;
          start_i = 0;
          chk(paused_o && !mem_req_o, "R9", "activity while paused", mem_req_o, 0);
        end
        chk(count_o == e_cnt, "R10", "start altered paused count", count_o, e_cnt);
        resume_i = 1;
        @(negedge clk); #1;
        resume_i = 0;
      end else if (do_restart && !restarted && e_cnt <= cnt - 1) begin
        restarted = 1;
        start_i = 1; dir_dec_i = ~d; src_seg_i = ~ss; dst_off_i = ~dof; count_i = 16'd0;
        @(negedge clk); #1;
        start_i = 0;
        chk(busy_o, "R10", "start during copy ended it", busy_o, 1);
      end else begin
        @(negedge clk); #1;
      end
      guard++;
    end
    chk(!active, "R3", "copy did not finish", e_cnt, 0);
    @(negedge clk); #1;
    chk(count_o == 0, "R3", "final count", count_o, 0);
    chk(src_off_o == e_soff, d ? "R5" : "R4", "final src offset", src_off_o, e_soff);
    chk(dst_off_o == e_doff, d ? "R5" : "R4", "final dst offset", dst_off_o, e_doff);
    chk(!busy_o && !mem_req_o, "R3", "not idle after done", busy_o, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!mem_req_o && !done_o && !busy_o && !paused_o && count_o == 0,
        "R11", "reset state", {mem_req_o, done_o, busy_o, count_o}, 0);
    #1 rst_n = 1;
    // directed corners
    run_copy(0, 0, 16'h1000, 16'h0010, 16'h2000, 16'h0020, 16'd5, 0, 0);
    run_copy(1, 0, 16'h0123, 16'h0100, 16'h0456, 16'h0200, 16'd4, 0, 0);
    run_copy(0, 1, 16'h3000, 16'h0040, 16'h3100, 16'h0080, 16'd6, 0, 0);   // R5
    run_copy(1, 1, 16'h0200, 16'h0002, 16'h0300, 16'h0001, 16'd4, 0, 0);   // R6 wrap down
    run_copy(0, 0, 16'h0400, 16'hfffe, 16'h0500, 16'hffff, 16'd4, 0, 0);   // R6 wrap up
    run_copy(1, 0, 16'hffff, 16'hfffc, 16'hfff0, 16'h00ff, 16'd5, 0, 0);   // R1 20-bit wrap
    run_copy(0, 0, 16'h0100, 16'h0000, 16'h0100, 16'h0001, 16'd6, 0, 0);   // overlapping
    run_copy(0, 0, 16'h0700, 16'h0000, 16'h0800, 16'h0000, 16'd0, 0, 0);   // R7
    run_copy(1, 0, 16'h0900, 16'h0010, 16'h0a00, 16'h0020, 16'd8, 1, 0);   // R9
    run_copy(0, 1, 16'h0b00, 16'h0050, 16'h0c00, 16'h0090, 16'd7, 0, 1);   // R10
    run_copy(0, 0, 16'h0d00, 16'h0000, 16'h0e00, 16'h0000, 16'd1, 0, 0);
    // random copies
    for (int i = 0; i < 30; i++) begin
      bit [15:0] so = ($urandom_range(0, 3) == 0) ? 16'(16'hfff8 + $urandom_range(0, 7))
                                                  : 16'($urandom);
      run_copy(1'($urandom), 1'($urandom), 16'($urandom), so, 16'($urandom),
               16'($urandom), 16'($urandom_range(0, 24)),
               ($urandom_range(0, 2) == 0), ($urandom_range(0, 4) == 0));
    end
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule